// File: doc/BRIEF.md
# UART Interrupt Status and Enable Controller

This block gathers fourteen single-cycle event pulses from a serial port's FIFOs, receiver, transmitter, break generator and modem-line logic into a sticky status register, masks them with an enable register, and drives one active-high level interrupt line. Software reads the status register to find out which events occurred, then writes ones back to acknowledge them. Writing back exactly the value just read acknowledges every event that was pending at that read.

The clear-to-send modem input is brought into the clock domain through a two-stage synchronizer. Its synchronized level can be read in a line status register. Any change of that level raises the CTS-toggled event. A small register port with a one-cycle registered read path gives access to the enable, status and line status registers.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge), the enable register and all status bits are zero and `irq` is low.
- R2: A pulse on `ev_in[i]` sets status bit i at that clock edge, whatever the enable bit. The bit positions are: 0 tx data empty, 1 rx data full, 2 tx FIFO almost empty, 3 tx FIFO empty, 4 rx FIFO almost full, 5 rx FIFO full, 6 tx underrun, 7 rx overrun, 8 parity error, 9 framing error, 10 CTS toggled, 11 rx timeout, 12 break done, 13 bus error response.
- R3: A status bit stays set until a register write to the status offset carries a 1 in that bit position. Writing a 0 leaves that bit unchanged.
- R4: If an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R5: `irq` is high exactly when some status bit and its enable bit are both 1. It changes at the same clock edge as the registers that cause the change.
- R6: The enable register sits at byte offset 0x14. It holds write data bits 13:0. Bits 14 and above of every read return zero.
- R7: The status register reads at byte offset 0x18. Writing back the value just read clears every bit that was set at that read.
- R8: Bit 4 of the line status register at offset 0x1C gives the CTS level after two synchronizer flops. A change on `cts_in` first shows in a read sampled at the third rising edge after the change. All other bits of that register read zero.
- R9: Any change of the synchronized CTS level, rising or falling, sets status bit 10 one edge after the level changes. `ev_in[10]` also sets that bit.
- R10: Reads of any other offset return zero, and writes to any other offset, or to 0x1C, change no register.
- R11: `reg_rdata` is registered. It presents the addressed register one edge after `reg_rd` is sampled high, and it is zero after any edge where `reg_rd` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | 14 | Single-cycle event pulses, one per status bit |
| cts_in | input | 1 | Asynchronous clear-to-send level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (8) | Byte offset of the register access |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Registered read data |
| irq | output | 1 | Level interrupt, high while an enabled status bit is set |

## Verification
The assertions assume that `rst` is held high from time zero until after the first rising edge, so that every register has a defined value before any past-value comparison. They also assume that `cts_in` is low during reset, because a high level there would look like a toggle once reset is released. The stimulus keeps to both. It drives `ev_in` only as pulses one cycle wide, and it issues a read and a write in separate cycles, so each read result can be traced to a single register state.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int EVT_W         = 14;
  localparam int EV_CTS_TOGGLE = 10;
  localparam int LSR_CTS_BIT   = 4;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_STATUS,
    SEL_LINE
  } reg_sel_e;
endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cts_async,
  output logic cts_level,
  output logic cts_toggle
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    genvar s;
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= cts_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[s] <= 1'b0;
          else     sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign cts_level  = sync_q[STAGES-1];
  assign cts_toggle = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] sts_q,
  output logic [W-1:0] sts_next
);
  // Clear applies first, so a same-cycle set survives.
  assign sts_next = (sts_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) sts_q <= '0;
    else     sts_q <= sts_next;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((sts_q & $past(set_vec)) == $past(set_vec))); // R4

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (clr_vec == '0) |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R3

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(set_vec)) == '0)); // R2
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import uart_irq_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter int          W          = 14,
  parameter logic [ADDR_W-1:0] OFS_ENABLE = 'h14,
  parameter logic [ADDR_W-1:0] OFS_STATUS = 'h18,
  parameter logic [ADDR_W-1:0] OFS_LINE   = 'h1C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      wdata_lo,
  input  logic [W-1:0]      sts_q,
  input  logic              cts_level,
  output logic [W-1:0]      clr_vec,
  output logic [W-1:0]      en_q,
  output logic [W-1:0]      en_next,
  output logic [DATA_W-1:0] reg_rdata
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    if      (reg_addr == OFS_ENABLE) sel = SEL_ENABLE;
    else if (reg_addr == OFS_STATUS) sel = SEL_STATUS;
    else if (reg_addr == OFS_LINE)   sel = SEL_LINE;
    else                             sel = SEL_NONE;
  end

  assign en_next = (reg_wr && sel == SEL_ENABLE) ? wdata_lo : en_q;
  assign clr_vec = (reg_wr && sel == SEL_STATUS) ? wdata_lo : '0;

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_ENABLE: rd_mux[W-1:0]       = en_q;
      SEL_STATUS: rd_mux[W-1:0]       = sts_q;
      SEL_LINE:   rd_mux[LSR_CTS_BIT] = cts_level;
      default:    rd_mux              = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      reg_rdata <= '0;
    end else begin
      en_q      <= en_next;
      reg_rdata <= reg_rd ? rd_mux : '0;
    end
  end

  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:W] == '0); // R6

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == '0)); // R11
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int CTS_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EVT_W-1:0]  ev_in,
  input  logic              cts_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic             cts_level;
  logic             cts_toggle;
  logic [EVT_W-1:0] set_vec;
  logic [EVT_W-1:0] clr_vec;
  logic [EVT_W-1:0] sts_q;
  logic [EVT_W-1:0] sts_next;
  logic [EVT_W-1:0] en_q;
  logic [EVT_W-1:0] en_next;

  cts_sync #(.STAGES(CTS_STAGES)) u_cts (
    .clk        (clk),
    .rst        (rst),
    .cts_async  (cts_in),
    .cts_level  (cts_level),
    .cts_toggle (cts_toggle)
  );

  always_comb begin
    set_vec                = ev_in;
    set_vec[EV_CTS_TOGGLE] = ev_in[EV_CTS_TOGGLE] | cts_toggle;
  end

  irq_status_reg #(.W(EVT_W)) u_status (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .sts_q    (sts_q),
    .sts_next (sts_next)
  );

  irq_reg_port #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .W      (EVT_W)
  ) u_port (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .wdata_lo  (reg_wdata[EVT_W-1:0]),
    .sts_q     (sts_q),
    .cts_level (cts_level),
    .clr_vec   (clr_vec),
    .en_q      (en_q),
    .en_next   (en_next),
    .reg_rdata (reg_rdata)
  );

  // Registered from next-state values so the line moves with the registers.
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(sts_next & en_next);
  end

  AST_IRQ_MATCHES: assert property (@(posedge clk) disable iff (rst)
    irq == |(sts_q & en_q)); // R5

  AST_CTS_TOGGLE_SETS: assert property (@(posedge clk) disable iff (rst)
    cts_toggle |=> sts_q[EV_CTS_TOGGLE]); // R9
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] ev_in = '0;
  logic        cts_in = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  uart_irq_ctrl i_uart_irq_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ev_in     (ev_in),
    .cts_in    (cts_in),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    tick();
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(logic [13:0] m);
    ev_in = m;
    tick();
    ev_in = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(8'h14, d); check("R1 enable", d, 32'h0);
    rd(8'h18, d); check("R1 status", d, 32'h0);
  endtask

  task automatic t_each_event();
    logic [31:0] d;
    for (int i = 0; i < 14; i++) begin
      pulse(14'(1 << i));
      rd(8'h18, d); check("R2 event bit", d, 32'(1 << i));
      check("R2 irq stays low", {31'b0, irq}, 32'h0);
      wr(8'h18, 32'h0);
      rd(8'h18, d); check("R3 write zero keeps", d, 32'(1 << i));
      wr(8'h18, 32'(1 << i));
      rd(8'h18, d); check("R3 write one clears", d, 32'h0);
    end
  endtask

  task automatic t_irq_mask();
    logic [31:0] d;
    wr(8'h14, 32'h0004);
    pulse(14'h0008);
    check("R5 masked event", {31'b0, irq}, 32'h0);
    pulse(14'h0004);
    check("R5 enabled event", {31'b0, irq}, 32'h1);
    wr(8'h18, 32'h0004);
    check("R5 irq drops on ack", {31'b0, irq}, 32'h0);
    rd(8'h18, d); check("R5 other bit kept", d, 32'h0008);
    wr(8'h14, 32'h0008);
    check("R5 enable on pending", {31'b0, irq}, 32'h1);
    wr(8'h14, 32'h0);
    check("R5 disable drops irq", {31'b0, irq}, 32'h0);
    wr(8'h18, 32'h3FFF);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    pulse(14'h0080);
    ev_in = 14'h0080;
    wr(8'h18, 32'h0080);
    ev_in = '0;
    rd(8'h18, d); check("R4 set beats clear", d, 32'h0080);
    wr(8'h18, 32'h0080);
    rd(8'h18, d); check("R4 later clear", d, 32'h0);
  endtask

  task automatic t_ack_all();
    logic [31:0] d;
    pulse(14'h2301);
    rd(8'h18, d); check("R7 read pending", d, 32'h2301);
    wr(8'h18, d);
    rd(8'h18, d); check("R7 writeback clears", d, 32'h0);
  endtask

  task automatic t_enable_width();
    logic [31:0] d;
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); check("R6 enable upper zero", d, 32'h3FFF);
    wr(8'h14, 32'h0000_1234);
    rd(8'h14, d); check("R6 enable value", d, 32'h1234);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h20, d); check("R10 unmapped read", d, 32'h0);
    rd(8'h14, d); check("R10 enable untouched", d, 32'h1234);
    rd(8'h18, d); check("R10 status untouched", d, 32'h0);
    tick();
    check("R11 idle rdata", reg_rdata, 32'h0);
    wr(8'h14, 32'h0);
  endtask

  task automatic t_cts();
    logic [31:0] d;
    cts_in = 1'b1;
    rd(8'h1C, d); check("R8 first edge", d, 32'h0);
    rd(8'h1C, d); check("R8 second edge", d, 32'h0);
    rd(8'h1C, d); check("R8 third edge", d, 32'h10);
    rd(8'h18, d); check("R9 rise sets bit 10", d, 32'h0400);
    wr(8'h18, 32'h0400);
    rd(8'h18, d); check("R9 single toggle", d, 32'h0);
    cts_in = 1'b0;
    tick(); tick(); tick();
    rd(8'h1C, d); check("R8 low level", d, 32'h0);
    rd(8'h18, d); check("R9 fall sets bit 10", d, 32'h0400);
    wr(8'h18, 32'h0400);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG && !done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    t_reset();
    t_each_event();
    t_irq_mask();
    t_set_wins();
    t_ack_all();
    t_enable_width();
    t_unmapped();
    t_cts();
    done = 1'b1;
    finish_run();
  end
endmodule